// File: doc/BRIEF.md
# Rollover Timer with Periodic Reload

This block is a 32-bit up-counting event timer driven from a small register bus. Software places a start value in a reload register and issues a start command. From then on the counter advances by one on every clock in which the functional tick input is high. When it passes the all-ones value it wraps and records an overflow. To get an overflow on the (N+1)th tick, software loads all-ones minus N.

The timer has two modes. In one-shot mode the run bit clears itself on the overflow and the counter rests at zero. In periodic mode the counter refills from the reload register on every overflow, so that register sets the period. Start commands and direct counter writes pass through a fixed resynchronisation delay before they act. The reload register, the interrupt enable and the status register act at once. The overflow flag is sticky and cleared by writing one to it. The level interrupt output is the flag gated by the enable.

The bus is a single request channel with a registered read response. A request is taken on every clock in which `req_valid` is high, and there is no back-pressure on it. The read response is a one-cycle pulse on `rsp_valid` that cannot be stalled, so the requester must be ready to take it.

Top module: `rollover_timer`

## Requirements
- R1: After reset, every register reads 0 (control, reload, counter, interrupt enable, status), `irq` is low and the counter is stopped.
- R2: Word addresses are 0 control (bit 0 run, bit 1 periodic), 1 reload, 2 counter, 3 interrupt enable (bit 0), 4 status (bit 0 overflow). Other addresses read 0. A read sampled at clock edge k returns the register value held before that edge, with `rsp_valid` high for exactly one cycle after edge k. Writes produce no response.
- R3: A control write with run set loads the counter from the reload register and starts counting. A counter write loads the counter directly. Both take effect at the 3rd clock edge after the edge that accepts the write, so three reads issued right after it still return the old count.
- R4: While running, the counter rises by exactly one on each clock edge where `tick` is high. While stopped, ticks leave it unchanged.
- R5: A tick with the counter at 0xFFFFFFFF is an overflow. It sets status bit 0, so a load of 0xFFFFFFFF minus N overflows on the (N+1)th tick.
- R6: On an overflow with the periodic bit clear, the run bit clears, the counter becomes 0 and it stays there under further ticks.
- R7: On an overflow with the periodic bit set, the counter reloads from the reload register and the run bit stays set, giving a period of 2^32 minus the reload value in ticks.
- R8: A reload write takes effect on the next edge, does not disturb a running counter and is used at the next overflow.
- R9: A control write with run clear freezes the counter after the same delay as R3 and leaves the reload register unchanged.
- R10: Writing 1 to status bit 0 clears it and writing 0 leaves it. An overflow in the same cycle as a clearing write leaves the bit set.
- R11: `irq` is high exactly while status bit 0 and enable bit 0 are both set, and it stays high until the status bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Functional count enable, one tick per high cycle |
| req_valid | input | 1 | Bus request present; always accepted |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 3 | Register word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid pulse, one cycle after the read |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | Level interrupt |

## Verification
Every result has a known due cycle. Reload, enable and status writes are visible on `irq` at the falling edge right after the accepting edge. Counter effects of a tick are visible one edge after the tick is sampled. Start, stop and counter writes act at the third edge after acceptance, which the bench confirms by finding the old count in the first three back-to-back reads and the new one in the fourth. Reads are placed in a queue of expected values when issued and compared when `rsp_valid` pulses one cycle later, and a pulse with nothing queued counts as an error.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned CNT_W  = 32;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_RELOAD = 3'd1,
    A_COUNT  = 3'd2,
    A_IRQEN  = 3'd3,
    A_STATUS = 3'd4
  } reg_addr_e;

  // command that must cross the resynchronisation delay
  typedef struct packed {
    logic             valid;
    logic             to_ctrl;  // 1: control write, 0: direct counter write
    logic [CNT_W-1:0] data;
  } cmd_t;
endpackage

// File: rtl/tmr_cmd_sync.sv
module tmr_cmd_sync
  import tmr_pkg::*;
#(
  parameter int unsigned STAGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  cmd_t cmd_in,
  output cmd_t cmd_out
);
  cmd_t pipe [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) pipe[0] <= '0;
        else        pipe[0] <= cmd_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) pipe[i] <= '0;
        else        pipe[i] <= pipe[i-1];
      end
    end
  end

  assign cmd_out = pipe[STAGES-1];
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  cmd_t             cmd,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             run,
  output logic             periodic,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic at_top;
  assign at_top = (count == ALL_ONES);
  // a pending command takes priority over a tick in the same cycle
  assign ovf    = run && tick && !cmd.valid && at_top;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      run      <= 1'b0;
      periodic <= 1'b0;
    end else if (cmd.valid) begin
      if (cmd.to_ctrl) begin
        run      <= cmd.data[0];
        periodic <= cmd.data[1];
        if (cmd.data[0]) count <= reload_val;
      end else begin
        count <= cmd.data;
      end
    end else if (run && tick) begin
      if (at_top) begin
        if (periodic) begin
          count <= reload_val;
        end else begin
          count <= '0;
          run   <= 1'b0;
        end
      end else begin
        count <= count + 1'b1;
      end
    end
  end

  // R4: one step per tick while running
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !cmd.valid && !at_top) |=> (count == $past(count) + 1'b1));

  // R6: one-shot overflow stops at zero
  a_r6_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !periodic) |=> (!run && count == '0));

  // R7: periodic overflow refills and keeps running
  a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && periodic) |=> (run && count == $past(reload_val)));

  // R9: a stopped counter does not move without a command
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cmd.valid) |=> $stable(count));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              run,
  input  logic              periodic,
  input  logic              ovf,
  output cmd_t              cmd_req,
  output logic [CNT_W-1:0]  reload_val,
  output logic              rsp_valid,
  output logic [CNT_W-1:0]  rsp_rdata,
  output logic              irq
);
  logic wr, rd;
  logic irq_en, ovf_flag, clr_flag;
  logic [CNT_W-1:0] rd_mux;

  assign wr       = req_valid && req_write;
  assign rd       = req_valid && !req_write;
  assign clr_flag = wr && (req_addr == A_STATUS) && req_wdata[0];

  always_comb begin
    cmd_req = '0;
    if (wr && req_addr == A_CTRL) begin
      cmd_req.valid   = 1'b1;
      cmd_req.to_ctrl = 1'b1;
      cmd_req.data    = req_wdata;
    end else if (wr && req_addr == A_COUNT) begin
      cmd_req.valid   = 1'b1;
      cmd_req.to_ctrl = 1'b0;
      cmd_req.data    = req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_val <= '0;
      irq_en     <= 1'b0;
      ovf_flag   <= 1'b0;
    end else begin
      if (wr && req_addr == A_RELOAD) reload_val <= req_wdata;
      if (wr && req_addr == A_IRQEN)  irq_en     <= req_wdata[0];
      if (ovf)           ovf_flag <= 1'b1;
      else if (clr_flag) ovf_flag <= 1'b0;
    end
  end

  always_comb begin
    case (req_addr)
      A_CTRL:   rd_mux = {{(CNT_W-2){1'b0}}, periodic, run};
      A_RELOAD: rd_mux = reload_val;
      A_COUNT:  rd_mux = count;
      A_IRQEN:  rd_mux = {{(CNT_W-1){1'b0}}, irq_en};
      A_STATUS: rd_mux = {{(CNT_W-1){1'b0}}, ovf_flag};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rd_mux;
    end
  end

  assign irq = ovf_flag && irq_en;

  // R10: an overflow always leaves the flag set
  a_r10_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf_flag);

  // R10: flag is sticky unless cleared by a write of one
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr_flag) |=> ovf_flag);

  // R11: interrupt holds until the flag or the enable is written
  a_r11_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_flag && !(wr && req_addr == A_IRQEN)) |=> irq);

  // R2: writes never produce a response
  a_r2_no_wr_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> !rsp_valid);
endmodule

// File: rtl/rollover_timer.sv
module rollover_timer
  import tmr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_wdata,
  output logic              rsp_valid,
  output logic [CNT_W-1:0]  rsp_rdata,
  output logic              irq
);
  cmd_t             cmd_req, cmd_due;
  logic [CNT_W-1:0] reload_val, count;
  logic             run, periodic, ovf;

  tmr_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .count      (count),
    .run        (run),
    .periodic   (periodic),
    .ovf        (ovf),
    .cmd_req    (cmd_req),
    .reload_val (reload_val),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .irq        (irq)
  );

  tmr_cmd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_in  (cmd_req),
    .cmd_out (cmd_due)
  );

  tmr_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .cmd        (cmd_due),
    .reload_val (reload_val),
    .count      (count),
    .run        (run),
    .periodic   (periodic),
    .ovf        (ovf)
  );
endmodule

// File: tb/rollover_timer_test.sv
module rollover_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [2:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  localparam logic [2:0] CTRL = 3'd0, RELOAD = 3'd1, COUNT = 3'd2,
                         IRQEN = 3'd3, STATUS = 3'd4;

  always #2 clk = ~clk;  // 250 MHz

  rollover_timer uut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .irq(irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string t);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  // all tasks are entered just after a falling edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  // monitor: response due one edge after the read is sampled
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: actual unexpected response %h expected none", rsp_rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(rsp_rdata, e, t);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state, R2 map and unused address
    chk({31'b0, irq}, 32'd0, "R1 irq after reset");
    rd(CTRL,   32'd0, "R1 ctrl");
    rd(RELOAD, 32'd0, "R1 reload");
    rd(COUNT,  32'd0, "R1 count");
    rd(IRQEN,  32'd0, "R1 irq enable");
    rd(STATUS, 32'd0, "R1 status");
    rd(3'd7,   32'd0, "R2 unused address");

    // one-shot, N = 5
    wr(RELOAD, 32'hFFFF_FFFA);
    chk({31'b0, rsp_valid}, 32'd0, "R2 no response to write");
    wr(CTRL, 32'h1);
    idle(3);
    rd(COUNT, 32'hFFFF_FFFA, "R3 start loads count");
    ticks(5);
    rd(COUNT, 32'hFFFF_FFFF, "R4 five ticks");
    rd(STATUS, 32'd0, "R5 no overflow before tick N+1");
    ticks(1);
    rd(STATUS, 32'd1, "R5 overflow on tick N+1");
    rd(CTRL, 32'd0, "R6 run self-clears");
    rd(COUNT, 32'd0, "R6 counter at zero");
    chk({31'b0, irq}, 32'd0, "R11 no irq while disabled");
    ticks(3);
    rd(COUNT, 32'd0, "R6 counter holds after stop");
    wr(IRQEN, 32'h1);
    chk({31'b0, irq}, 32'd1, "R11 irq on enable");
    wr(STATUS, 32'h0);
    chk({31'b0, irq}, 32'd1, "R10 zero write keeps flag");
    wr(STATUS, 32'h1);
    chk({31'b0, irq}, 32'd0, "R10 one write clears flag");
    rd(STATUS, 32'd0, "R10 status cleared");

    // periodic, period 3
    wr(RELOAD, 32'hFFFF_FFFD);
    wr(CTRL, 32'h3);
    idle(3);
    rd(COUNT, 32'hFFFF_FFFD, "R3 periodic start");
    ticks(2);
    rd(COUNT, 32'hFFFF_FFFF, "R4 periodic count");
    chk({31'b0, irq}, 32'd0, "R11 irq low before overflow");
    ticks(1);
    chk({31'b0, irq}, 32'd1, "R11 irq on overflow");
    rd(COUNT, 32'hFFFF_FFFD, "R7 reload on overflow");
    rd(CTRL, 32'd3, "R7 run stays set");
    wr(STATUS, 32'h1);
    chk({31'b0, irq}, 32'd0, "R11 irq cleared");
    ticks(3);
    chk({31'b0, irq}, 32'd1, "R7 second period overflow");
    wr(RELOAD, 32'hFFFF_FFF0);
    rd(COUNT, 32'hFFFF_FFFD, "R8 reload write leaves count");
    rd(RELOAD, 32'hFFFF_FFF0, "R8 reload readback");
    wr(STATUS, 32'h1);
    ticks(3);
    rd(COUNT, 32'hFFFF_FFF0, "R8 new reload used at overflow");
    ticks(15);
    rd(COUNT, 32'hFFFF_FFFF, "R4 fifteen ticks");
    // clear and overflow in the same cycle
    req_valid = 1; req_write = 1; req_addr = STATUS; req_wdata = 32'h1; tick = 1;
    @(negedge clk);
    req_valid = 0; req_write = 0; tick = 0;
    chk({31'b0, irq}, 32'd1, "R10 overflow beats clear");
    rd(STATUS, 32'd1, "R10 status kept");
    rd(COUNT, 32'hFFFF_FFF0, "R7 reload again");
    wr(STATUS, 32'h1);
    chk({31'b0, irq}, 32'd0, "R11 irq low after clear");

    // stop
    wr(CTRL, 32'h0);
    idle(3);
    rd(CTRL, 32'd0, "R9 stopped");
    ticks(4);
    rd(COUNT, 32'hFFFF_FFF0, "R9 count frozen");
    rd(RELOAD, 32'hFFFF_FFF0, "R9 reload unchanged");
    chk({31'b0, irq}, 32'd0, "R9 no overflow while stopped");

    // direct counter write latency
    wr(COUNT, 32'h0000_1234);
    rd(COUNT, 32'hFFFF_FFF0, "R3 old count read 1");
    rd(COUNT, 32'hFFFF_FFF0, "R3 old count read 2");
    rd(COUNT, 32'hFFFF_FFF0, "R3 old count read 3");
    rd(COUNT, 32'h0000_1234, "R3 new count read 4");
    ticks(2);
    rd(COUNT, 32'h0000_1234, "R4 ticks ignored when stopped");

    idle(3);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2: actual %0d responses missing expected 0", exp_q.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule